// File: doc/BRIEF.md
# Dual ADC Conversion Sequencer

This block controls two analog-to-digital converter cores. Each core appears only as a start pulse with a channel number and a done strobe that returns a 12-bit result. On a start request the sequencer picks the channel for each conversion and issues the core start pulses in the order the selected pairing mode calls for. It files every returned result into one of two result slots per core and raises end-of-conversion flags. Each flag drives an interrupt through its own enable.

Four pairing modes are available. Mode 0 runs the two cores as separate converters. Mode 1 keeps separate triggers but reports one merged completion. Mode 2 starts both cores together from the core 0 trigger. Mode 3 runs an interleaved chain of core 0, core 1, core 0, core 1, which a length select can cut to three conversions. Configuration arrives as static inputs from a register file outside this block. The software start and the external start pin are merged outside into one start request per core.

Top module: `dual_adc_seq`

## Requirements
- R1: While `en` is 0, no core start pulse is issued and a start request is ignored. Dropping `en` during a conversion clears busy at once, and a done strobe that arrives afterwards is discarded, so no slot becomes valid and no flag rises.
- R2: In mode 0 (`mode`=2'b00), a start request on an idle core gives exactly one one-cycle start pulse on that core, with the core's primary channel. The result goes to that core's slot 0 and sets that core's own flag (`eoc0` or `eoc1`).
- R3: In mode 1 (`mode`=2'b01), each core starts from its own request. `eoc0` rises only after both cores have delivered a result, and `eoc1` never rises.
- R4: In mode 2 (`mode`=2'b10), `start0` starts both cores in the same cycle on their primary channels, and `start1` alone has no effect. `eoc0` rises once both results are stored, and `eoc1` stays 0.
- R5: In mode 3 (`mode`=2'b11) with `short3`=0, `start0` runs four conversions in this order: core 0 primary, core 1 primary, core 0 second input, core 1 second input. Each step starts only after the previous done. First results go to slot 0 and second results to slot 1, and `eoc0` rises at the end.
- R6: In mode 3 with `short3`=1, the chain stops after the third conversion (core 0 second input). Core 1 slot 1 is left untouched, and `eoc0` rises then.
- R7: A core's busy output rises the cycle after its accepted start and falls with the final done of its conversion or chain. In mode 3, `busy0` covers the whole chain. A start request while busy is ignored.
- R8: Storing a result sets the slot's valid flag. It also sets the slot's overrun flag if the slot was still valid. A one-cycle `rd_en` with `rd_slot`=s clears valid and overrun of slot s for both cores, and the slot data is readable combinationally through `rd_slot`.
- R9: Driving `eoc_clr0`/`eoc_clr1` high for one cycle clears the matching flag. `irq0`/`irq1` is high exactly while the flag and its enable `ien0`/`ien1` are both 1.
- R10: A done strobe from a core with no conversion outstanding changes no slot and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Global converter enable |
| mode | input | 2 | Pairing mode 0..3 |
| short3 | input | 1 | Mode 3 chain length: 1 selects three conversions |
| ien0 | input | 1 | Interrupt enable for flag 0 |
| ien1 | input | 1 | Interrupt enable for flag 1 |
| pri0 | input | 3 | Core 0 primary channel |
| sec0 | input | 3 | Core 0 second-input channel |
| pri1 | input | 3 | Core 1 primary channel |
| sec1 | input | 3 | Core 1 second-input channel |
| start0 | input | 1 | Start request for core 0 |
| start1 | input | 1 | Start request for core 1 |
| core0_start | output | 1 | One-cycle start pulse to core 0 |
| core0_ch | output | 3 | Channel for core 0's conversion |
| core0_done | input | 1 | Core 0 result strobe |
| core0_result | input | 12 | Core 0 result |
| core1_start | output | 1 | One-cycle start pulse to core 1 |
| core1_ch | output | 3 | Channel for core 1's conversion |
| core1_done | input | 1 | Core 1 result strobe |
| core1_result | input | 12 | Core 1 result |
| busy0 | output | 1 | Core 0 (or mode 3 chain) busy |
| busy1 | output | 1 | Core 1 busy |
| eoc0 | output | 1 | End-of-conversion flag 0 |
| eoc1 | output | 1 | End-of-conversion flag 1 |
| eoc_clr0 | input | 1 | Write-one clear of flag 0 |
| eoc_clr1 | input | 1 | Write-one clear of flag 1 |
| irq0 | output | 1 | Interrupt 0 |
| irq1 | output | 1 | Interrupt 1 |
| rd_slot | input | 1 | Result slot to view |
| rd_en | input | 1 | Read strobe that clears the viewed slot's flags |
| rd_data0 | output | 12 | Core 0 result in the viewed slot |
| rd_valid0 | output | 1 | Core 0 valid flag of the viewed slot |
| rd_ovr0 | output | 1 | Core 0 overrun flag of the viewed slot |
| rd_data1 | output | 12 | Core 1 result in the viewed slot |
| rd_valid1 | output | 1 | Core 1 valid flag of the viewed slot |
| rd_ovr1 | output | 1 | Core 1 overrun flag of the viewed slot |

## Verification
The bench builds the block with its defaults: 12-bit results and 3-bit channel codes. With those widths all eight channel codes of both cores can be swept in mode 0. The bench core models return results tagged with the channel they were asked for, so each stored word shows both the routing and the slot it landed in. Unequal core latencies in modes 1 and 2 make the merged flag wait on the slower core, and a long latency lets `en` drop mid-conversion.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
    localparam int NCORE = 2;
    localparam int NSLOT = 2;

    typedef enum logic [1:0] {
        MODE_INDEP  = 2'b00,
        MODE_MERGED = 2'b01,
        MODE_SIMUL  = 2'b10,
        MODE_CHAIN  = 2'b11
    } seq_mode_e;
endpackage

// File: rtl/dseq_ctrl.sv
module dseq_ctrl
    import dseq_pkg::*;
#(
    parameter int CH_W = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en,
    input  logic [1:0]                  mode,
    input  logic                        short3,
    input  logic [NCORE-1:0][CH_W-1:0]  pri,
    input  logic [NCORE-1:0][CH_W-1:0]  sec,
    input  logic [NCORE-1:0]            start,
    input  logic [NCORE-1:0]            done,
    input  logic [NCORE-1:0]            eoc_clr,
    output logic [NCORE-1:0]            go,
    output logic [NCORE-1:0][CH_W-1:0]  go_ch,
    output logic [NCORE-1:0]            busy,
    output logic [NCORE-1:0]            eoc,
    output logic [NCORE-1:0]            wr,
    output logic [NCORE-1:0]            wr_slot
);
    typedef struct packed {
        logic [NCORE-1:0]           busy;
        logic [NCORE-1:0]           pend;
        logic [NCORE-1:0]           fin;
        logic [NCORE-1:0]           go;
        logic [NCORE-1:0]           eoc;
        logic [1:0]                 step;
        logic [NCORE-1:0][CH_W-1:0] ch;
    } ctrl_t;

    ctrl_t q, d;
    logic [NCORE-1:0] acc, evt;
    seq_mode_e mode_e;

    assign mode_e = seq_mode_e'(mode);
    assign acc    = q.pend & done;

    always_comb begin
        d       = q;
        d.go    = '0;
        wr      = '0;
        wr_slot = '0;
        evt     = '0;
        if (!en) begin
            d.busy = '0;
            d.pend = '0;
            d.fin  = '0;
            d.step = '0;
        end else begin
            case (mode_e)
                MODE_INDEP, MODE_MERGED: begin
                    for (int k = 0; k < NCORE; k++) begin
                        if (acc[k]) begin
                            d.pend[k] = 1'b0;
                            d.busy[k] = 1'b0;
                            wr[k]     = 1'b1;
                            if (mode_e == MODE_INDEP) evt[k] = 1'b1;
                            else                      d.fin[k] = 1'b1;
                        end else if (start[k] && !q.busy[k]) begin
                            d.busy[k] = 1'b1;
                            d.go[k]   = 1'b1;
                            d.pend[k] = 1'b1;
                            d.ch[k]   = pri[k];
                        end
                    end
                    if (mode_e == MODE_MERGED && d.fin == '1) begin
                        evt[0] = 1'b1;
                        d.fin  = '0;
                    end
                end
                MODE_SIMUL: begin
                    for (int k = 0; k < NCORE; k++) begin
                        if (acc[k]) begin
                            d.pend[k] = 1'b0;
                            d.fin[k]  = 1'b1;
                            wr[k]     = 1'b1;
                        end
                    end
                    if (d.fin == '1) begin
                        evt[0] = 1'b1;
                        d.fin  = '0;
                        d.busy = '0;
                    end else if (start[0] && q.busy == '0) begin
                        d.busy = '1;
                        d.go   = '1;
                        d.pend = '1;
                        d.ch   = pri;
                    end
                end
                default: begin
                    if (acc[0]) begin
                        d.pend[0]  = 1'b0;
                        wr[0]      = 1'b1;
                        wr_slot[0] = q.step[1];
                        if (q.step[1] && short3) begin
                            evt[0]    = 1'b1;
                            d.busy[0] = 1'b0;
                        end else begin
                            d.go[1]   = 1'b1;
                            d.pend[1] = 1'b1;
                            d.ch[1]   = q.step[1] ? sec[1] : pri[1];
                            d.step    = q.step + 2'd1;
                        end
                    end else if (acc[1]) begin
                        d.pend[1]  = 1'b0;
                        wr[1]      = 1'b1;
                        wr_slot[1] = q.step[1];
                        if (q.step[1]) begin
                            evt[0]    = 1'b1;
                            d.busy[0] = 1'b0;
                        end else begin
                            d.go[0]   = 1'b1;
                            d.pend[0] = 1'b1;
                            d.ch[0]   = sec[0];
                            d.step    = 2'd2;
                        end
                    end else if (start[0] && q.busy == '0) begin
                        d.busy[0] = 1'b1;
                        d.go[0]   = 1'b1;
                        d.pend[0] = 1'b1;
                        d.ch[0]   = pri[0];
                        d.step    = 2'd0;
                    end
                end
            endcase
        end
        d.eoc = (q.eoc & ~eoc_clr) | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign go    = q.go;
    assign go_ch = q.ch;
    assign busy  = q.busy;
    assign eoc   = q.eoc;

    p_no_go_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (go == '0));
    p_go_single_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        go[0] |=> !go[0]);
    p_chain_one_at_a_time_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_e == MODE_CHAIN && busy[0]) |-> !(go[0] && go[1]));
    p_go_while_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        go[0] |-> busy[0]);
    p_flag_needs_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |-> (acc != '0));
endmodule

// File: rtl/dseq_slots.sv
module dseq_slots
    import dseq_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NCORE-1:0]              wr,
    input  logic [NCORE-1:0]              wr_slot,
    input  logic [NCORE-1:0][DATA_W-1:0]  res,
    input  logic                          rd_en,
    input  logic                          rd_slot,
    output logic [NCORE-1:0][DATA_W-1:0]  rd_data,
    output logic [NCORE-1:0]              rd_valid,
    output logic [NCORE-1:0]              rd_ovr
);
    typedef struct packed {
        logic [NCORE-1:0][NSLOT-1:0][DATA_W-1:0] data;
        logic [NCORE-1:0][NSLOT-1:0]             vld;
        logic [NCORE-1:0][NSLOT-1:0]             ovr;
    } slots_t;

    slots_t q, d;

    always_comb begin
        d = q;
        for (int k = 0; k < NCORE; k++) begin
            if (rd_en) begin
                d.vld[k][rd_slot] = 1'b0;
                d.ovr[k][rd_slot] = 1'b0;
            end
            if (wr[k]) begin
                d.ovr[k][wr_slot[k]]  = d.vld[k][wr_slot[k]];
                d.vld[k][wr_slot[k]]  = 1'b1;
                d.data[k][wr_slot[k]] = res[k];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    for (genvar k = 0; k < NCORE; k++) begin : g_view
        assign rd_data[k]  = q.data[k][rd_slot];
        assign rd_valid[k] = q.vld[k][rd_slot];
        assign rd_ovr[k]   = q.ovr[k][rd_slot];

        p_ovr_implies_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (q.ovr[k] & ~q.vld[k]) == '0);
    end
endmodule

// File: rtl/dual_adc_seq.sv
module dual_adc_seq
    import dseq_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int CH_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        mode,
    input  logic              short3,
    input  logic              ien0,
    input  logic              ien1,
    input  logic [CH_W-1:0]   pri0,
    input  logic [CH_W-1:0]   sec0,
    input  logic [CH_W-1:0]   pri1,
    input  logic [CH_W-1:0]   sec1,
    input  logic              start0,
    input  logic              start1,
    output logic              core0_start,
    output logic [CH_W-1:0]   core0_ch,
    input  logic              core0_done,
    input  logic [DATA_W-1:0] core0_result,
    output logic              core1_start,
    output logic [CH_W-1:0]   core1_ch,
    input  logic              core1_done,
    input  logic [DATA_W-1:0] core1_result,
    output logic              busy0,
    output logic              busy1,
    output logic              eoc0,
    output logic              eoc1,
    input  logic              eoc_clr0,
    input  logic              eoc_clr1,
    output logic              irq0,
    output logic              irq1,
    input  logic              rd_slot,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data0,
    output logic              rd_valid0,
    output logic              rd_ovr0,
    output logic [DATA_W-1:0] rd_data1,
    output logic              rd_valid1,
    output logic              rd_ovr1
);
    logic [NCORE-1:0]             go, busy, eoc, wr, wr_slot, rvld, rovr;
    logic [NCORE-1:0][CH_W-1:0]   go_ch;
    logic [NCORE-1:0][DATA_W-1:0] rdat;

    dseq_ctrl #(.CH_W(CH_W)) ctrl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .mode    (mode),
        .short3  (short3),
        .pri     ({pri1, pri0}),
        .sec     ({sec1, sec0}),
        .start   ({start1, start0}),
        .done    ({core1_done, core0_done}),
        .eoc_clr ({eoc_clr1, eoc_clr0}),
        .go      (go),
        .go_ch   (go_ch),
        .busy    (busy),
        .eoc     (eoc),
        .wr      (wr),
        .wr_slot (wr_slot)
    );

    dseq_slots #(.DATA_W(DATA_W)) slots_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr),
        .wr_slot  (wr_slot),
        .res      ({core1_result, core0_result}),
        .rd_en    (rd_en),
        .rd_slot  (rd_slot),
        .rd_data  (rdat),
        .rd_valid (rvld),
        .rd_ovr   (rovr)
    );

    assign core0_start = go[0];
    assign core1_start = go[1];
    assign core0_ch    = go_ch[0];
    assign core1_ch    = go_ch[1];
    assign busy0       = busy[0];
    assign busy1       = busy[1];
    assign eoc0        = eoc[0];
    assign eoc1        = eoc[1];
    assign irq0        = eoc[0] & ien0;
    assign irq1        = eoc[1] & ien1;
    assign rd_data0    = rdat[0];
    assign rd_data1    = rdat[1];
    assign rd_valid0   = rvld[0];
    assign rd_valid1   = rvld[1];
    assign rd_ovr0     = rovr[0];
    assign rd_ovr1     = rovr[1];

    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc0 && eoc_clr0 && !core0_done && !core1_done) |=> !eoc0);
endmodule

// File: tb/dual_adc_seq_tb_top.sv
`timescale 1ns/1ps
module dual_adc_seq_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic en = 0, short3 = 0, ien0 = 0, ien1 = 0;
    logic [1:0] mode = 0;
    logic [2:0] pri0 = 0, sec0 = 0, pri1 = 0, sec1 = 0;
    logic start0 = 0, start1 = 0, eoc_clr0 = 0, eoc_clr1 = 0, rd_slot = 0, rd_en = 0;
    logic core0_start, core1_start, busy0, busy1, eoc0, eoc1, irq0, irq1;
    logic [2:0] core0_ch, core1_ch;
    logic rd_valid0, rd_ovr0, rd_valid1, rd_ovr1;
    logic [11:0] rd_data0, rd_data1;

    logic [1:0] mdone = 0, spur = 0;
    logic [11:0] mres [2];
    logic [11:0] spur_res = 0;
    logic core0_done, core1_done;
    logic [11:0] core0_result, core1_result;
    assign core0_done   = mdone[0] | spur[0];
    assign core1_done   = mdone[1] | spur[1];
    assign core0_result = spur[0] ? spur_res : mres[0];
    assign core1_result = spur[1] ? spur_res : mres[1];

    dual_adc_seq dut_i (.*);

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_bad = 0;
    int lat [2];
    int ncv [2];
    int ch_log [2][16];
    int cyc_log [2][16];
    logic [11:0] res_log [2][16];
    int tag = 1;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic core_model(int k);
        logic g;
        logic [2:0] c;
        forever begin
            @(negedge clk);
            g = (k == 0) ? core0_start : core1_start;
            c = (k == 0) ? core0_ch : core1_ch;
            if (g) begin
                int idx = ncv[k];
                logic [11:0] r = {c, 9'(tag * 7 + k)};
                tag++;
                if (idx < 16) begin
                    ch_log[k][idx]  = int'(c);
                    cyc_log[k][idx] = cyc;
                    res_log[k][idx] = r;
                end
                ncv[k] = idx + 1;
                repeat (lat[k]) @(negedge clk);
                mres[k]  = r;
                mdone[k] = 1'b1;
                @(negedge clk);
                mdone[k] = 1'b0;
            end
        end
    endtask

    task automatic pulse_start(int k);
        @(negedge clk);
        if (k == 0) start0 = 1; else start1 = 1;
        @(negedge clk);
        start0 = 0; start1 = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 300; i++) begin
            if (!busy0 && !busy1 && mdone == 0) break;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic read_slot(int s);
        @(negedge clk);
        rd_slot = s[0];
        rd_en = 1;
        @(negedge clk);
        rd_en = 0;
    endtask

    task automatic setup(logic [1:0] m, logic sh);
        @(negedge clk);
        en = 0;
        eoc_clr0 = 1; eoc_clr1 = 1;
        @(negedge clk);
        eoc_clr0 = 0; eoc_clr1 = 0;
        read_slot(0);
        read_slot(1);
        mode = m; short3 = sh;
        ncv[0] = 0; ncv[1] = 0;
        @(negedge clk);
        en = 1;
    endtask

    task automatic view(int s);
        rd_slot = s[0];
        #0.5;
    endtask

    initial begin
        lat[0] = 2; lat[1] = 2; ncv[0] = 0; ncv[1] = 0;
        mres[0] = 0; mres[1] = 0;
        fork core_model(0); core_model(1); join_none
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // Reset state
        chk("R7 reset busy", {busy1, busy0}, 0);
        chk("R9 reset flags", {eoc1, eoc0, irq1, irq0}, 0);
        view(0);
        chk("R8 reset valid", {rd_valid1, rd_valid0, rd_ovr1, rd_ovr0}, 0);

        // R1: disabled start ignored
        pulse_start(0);
        repeat (4) @(negedge clk);
        chk("R1 no start while off", ncv[0], 0);
        chk("R1 busy while off", busy0, 0);

        // R2: mode 0 sweep of all channel codes
        for (int p = 0; p < 8; p++) begin
            setup(2'b00, 0);
            pri0 = 3'(p); pri1 = 3'(7 - p);
            lat[0] = p % 3; lat[1] = 1 + p % 4;
            fork pulse_start(0); pulse_start(1); join
            wait_idle();
            chk("R2 core0 pulses", ncv[0], 1);
            chk("R2 core1 pulses", ncv[1], 1);
            chk("R2 core0 channel", ch_log[0][0], p);
            chk("R2 core1 channel", ch_log[1][0], 7 - p);
            view(0);
            chk("R2 core0 slot0", int'(rd_data0), int'(res_log[0][0]));
            chk("R2 core1 slot0", int'(rd_data1), int'(res_log[1][0]));
            chk("R2 own flags", {eoc1, eoc0}, 3);
        end

        // R9: interrupt enables and write-one clear
        ien0 = 0; #0.5;
        chk("R9 irq0 masked", irq0, 0);
        ien0 = 1; ien1 = 1; #0.5;
        chk("R9 irq0 enabled", irq0, 1);
        @(negedge clk); eoc_clr0 = 1; @(negedge clk); eoc_clr0 = 0;
        chk("R9 eoc0 cleared", eoc0, 0);
        chk("R9 irq0 cleared", irq0, 0);
        chk("R9 eoc1 kept", {eoc1, irq1}, 3);

        // R8: overrun and read clear
        setup(2'b00, 0);
        lat[0] = 1;
        pulse_start(0); wait_idle();
        pulse_start(0); wait_idle();
        view(0);
        chk("R8 valid after two", rd_valid0, 1);
        chk("R8 overrun", rd_ovr0, 1);
        chk("R8 newest data", int'(rd_data0), int'(res_log[0][1]));
        view(1);
        chk("R8 slot1 untouched", rd_valid0, 0);
        read_slot(0);
        view(0);
        chk("R8 read clears", {rd_valid0, rd_ovr0}, 0);

        // R7: start while busy ignored
        setup(2'b00, 0);
        lat[0] = 10;
        pulse_start(0);
        chk("R7 busy after start", busy0, 1);
        pulse_start(0);
        wait_idle();
        chk("R7 busy start ignored", ncv[0], 1);
        chk("R7 busy dropped", busy0, 0);

        // R1: drop enable mid-conversion
        setup(2'b00, 0);
        lat[0] = 20;
        pulse_start(0);
        repeat (3) @(negedge clk);
        en = 0;
        @(negedge clk);
        chk("R1 busy cleared", busy0, 0);
        repeat (25) @(negedge clk);
        view(0);
        chk("R1 late done dropped", rd_valid0, 0);
        chk("R1 no flag", eoc0, 0);

        // R10: stray done while idle
        setup(2'b00, 0);
        @(negedge clk); spur = 2'b11; spur_res = 12'h5A5;
        @(negedge clk); spur = 0;
        @(negedge clk);
        view(0);
        chk("R10 stray done", {rd_valid1, rd_valid0}, 0);
        chk("R10 stray flag", {eoc1, eoc0}, 0);

        // R3: merged completion
        setup(2'b01, 0);
        lat[0] = 1; lat[1] = 12;
        fork pulse_start(0); pulse_start(1); join
        for (int i = 0; i < 50 && busy0; i++) @(negedge clk);
        chk("R3 core1 still busy", busy1, 1);
        chk("R3 no flag before both", eoc0, 0);
        wait_idle();
        chk("R3 merged flag", eoc0, 1);
        chk("R3 no flag1", eoc1, 0);

        // R4: simultaneous pair
        setup(2'b10, 0);
        pri0 = 3'd5; pri1 = 3'd2;
        lat[0] = 3; lat[1] = 6;
        pulse_start(1); wait_idle();
        chk("R4 start1 ignored", ncv[0] + ncv[1], 0);
        pulse_start(0); wait_idle();
        chk("R4 both ran", ncv[0] * 10 + ncv[1], 11);
        chk("R4 same cycle", cyc_log[0][0], cyc_log[1][0]);
        chk("R4 channels", ch_log[0][0] * 8 + ch_log[1][0], 42);
        chk("R4 flags", {eoc1, eoc0}, 1);
        view(0);
        chk("R4 slots", int'(rd_data1), int'(res_log[1][0]));

        // R5: four-step chain
        setup(2'b11, 0);
        pri0 = 3'd1; sec0 = 3'd2; pri1 = 3'd3; sec1 = 3'd4;
        lat[0] = 2; lat[1] = 1;
        pulse_start(0); wait_idle();
        chk("R5 counts", ncv[0] * 10 + ncv[1], 22);
        chk("R5 channels", ch_log[0][0]*1000 + ch_log[1][0]*100 + ch_log[0][1]*10 + ch_log[1][1], 1324);
        chk("R5 order", int'(cyc_log[0][0] < cyc_log[1][0] && cyc_log[1][0] < cyc_log[0][1]
                              && cyc_log[0][1] < cyc_log[1][1]), 1);
        view(0);
        chk("R5 slot0 core0", int'(rd_data0), int'(res_log[0][0]));
        chk("R5 slot0 core1", int'(rd_data1), int'(res_log[1][0]));
        view(1);
        chk("R5 slot1 core0", int'(rd_data0), int'(res_log[0][1]));
        chk("R5 slot1 core1", int'(rd_data1), int'(res_log[1][1]));
        chk("R5 flags", {eoc1, eoc0}, 1);

        // R6: three-step chain
        setup(2'b11, 1);
        pulse_start(0); wait_idle();
        chk("R6 counts", ncv[0] * 10 + ncv[1], 21);
        chk("R6 third channel", ch_log[0][1], 2);
        view(1);
        chk("R6 slot1 core0", int'(rd_data0), int'(res_log[0][1]));
        chk("R6 slot1 core1 untouched", rd_valid1, 0);
        chk("R6 flag", eoc0, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        wait (cyc == 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule